// File: doc/BRIEF.md
# Two-Clock Byte Queue, Thirteen Entries

This block moves bytes from a producer on one clock to a consumer on an unrelated clock. The producer raises `wr_en` with a byte on `wr_data`. On each rising write-clock edge where the queue has room, that byte is stored. The consumer raises `rd_en`. On each rising read-clock edge where data is held, the oldest byte is loaded into `rd_data`, and `rd_valid` marks it as valid for the following cycle. The write side sees `wr_full` and the read side sees `rd_empty`, and both flags are computed locally in their own domains.

The queue holds thirteen entries, which is not a power of two. Each side therefore keeps two things. One is a 4-bit slot index that wraps from 12 to 0. The other is a 13-bit twisted-ring (Johnson) position code with 26 states, covering two laps of the array, in which exactly one bit changes per step, including at the wrap. Only this code crosses to the other clock, through two synchronizer flops. The queue is empty when the two codes are equal. It is full when one code is the bitwise inverse of the other, because the state thirteen steps ahead is always the complement.

A single active-low reset clears both sides at once, without waiting for a clock. Each domain leaves reset in step with its own clock.

Top module: `xclk_fifo13`

## Requirements
- R1: While `rst_n` is low, and after it rises, both pointers are cleared without a clock edge. Each side then leaves reset on its own clock with `rd_empty`=1, `wr_full`=0 and `rd_valid`=0.
- R2: Bytes leave on `rd_data` in exactly the order in which they were accepted, with none lost and none repeated.
- R3: The queue accepts 13 bytes with no reads. `wr_full` stays 0 after 12 accepted bytes and reads 1 right after the write edge that stores the 13th.
- R4: A write-clock edge with `wr_en`=1 while `wr_full`=1 stores nothing and leaves the write position unchanged, and no stored byte is overwritten.
- R5: A read-clock edge with `rd_en`=1 while `rd_empty`=1 leaves the read position unchanged and leaves `rd_valid`=0 after that edge.
- R6: A read-clock edge with `rd_en`=1 and `rd_empty`=0 loads the oldest byte into `rd_data` and sets `rd_valid`=1 after that edge. Any other read edge leaves `rd_valid`=0.
- R7: Slot indexes stay in 0..12 and wrap from 12 to 0. Ordering holds across many wraps under mixed read and write rates.
- R8: Each position code changes in at most one bit per edge of its own clock, including at the wrap.
- R9: The flags are pessimistic but clear within a few cycles. After a read frees a slot, `wr_full` drops within a bounded number of write cycles. After a write, `rd_empty` drops within a bounded number of read cycles.
- R10: Reset applied in mid-operation discards all held bytes. The first byte read afterwards is the first byte written after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock, unrelated to `wr_clk` |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Write request, sampled on `wr_clk` rising edges |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | No free slot seen from the write side |
| rd_en | input | 1 | Read request, sampled on `rd_clk` rising edges |
| rd_data | output | 8 | Byte loaded by the last accepted read |
| rd_valid | output | 1 | `rd_data` holds a byte loaded at the last read edge |
| rd_empty | output | 1 | No held byte seen from the read side |

## Verification
Some rules are checked by the assertions on every edge. A refused write or read must leave its position code frozen. An accepted write must advance the code. Every position code may move in at most one bit per edge, and slot indexes must stay below thirteen. Other behaviour only the bench scenarios can show, through a queue of expected bytes:
- the byte order across many wraps;
- that a write attempted while full never overwrites stored data;
- exactly when `wr_full` rises;
- how soon the pessimistic flags clear;
- that a mid-stream reset discards stale bytes.

// File: rtl/xf13_pkg.sv
package xf13_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_DEPTH  = 13;
    localparam int unsigned DEF_SYNC   = 2;

    // slot index step with wrap at lim-1 back to zero
    function automatic int unsigned wrap_next(input int unsigned v, input int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/xf13_rstsync.sv
// Asserts at once on rst_n low, releases on the second clock edge after rst_n rises.
module xf13_rstsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst
);
    logic [STAGES-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold <= '1;
        else        hold <= {hold[STAGES-2:0], 1'b0};
    end

    assign rst = hold[STAGES-1];
endmodule

// File: rtl/xf13_sync.sv
// Multi-flop crossing of a code that moves one bit at a time.
module xf13_sync #(
    parameter int unsigned W      = 13,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xf13_ptr.sv
// Position keeper: twisted-ring code (2*DEPTH states) plus a binary slot index.
module xf13_ptr #(
    parameter int unsigned DEPTH = 13,
    parameter int unsigned IDX_W = 4,
    localparam int unsigned JC_W = DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [JC_W-1:0]  code,
    output logic [IDX_W-1:0] idx
);
    logic [JC_W-1:0]  code_nx;
    logic [IDX_W-1:0] idx_nx;

    always_comb begin
        code_nx = {code[JC_W-2:0], ~code[JC_W-1]};
        idx_nx  = IDX_W'(xf13_pkg::wrap_next(32'(idx), DEPTH));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            code <= '0;
            idx  <= '0;
        end else if (step) begin
            code <= code_nx;
            idx  <= idx_nx;
        end
    end
endmodule

// File: rtl/xf13_mem.sv
// Storage: written on the write clock, read combinationally by slot index.
module xf13_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 13,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xclk_fifo13.sv
module xclk_fifo13 #(
    parameter int unsigned DATA_W = xf13_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = xf13_pkg::DEF_DEPTH,
    parameter int unsigned SYNC   = xf13_pkg::DEF_SYNC
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned JC_W  = DEPTH;

    logic             wr_rst, rd_rst;
    logic [JC_W-1:0]  wr_code, rd_code, rd_code_w, wr_code_r;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DATA_W-1:0] mem_q;
    logic             wr_fire, rd_fire;

    xf13_rstsync #(.STAGES(SYNC)) u_wrst (.clk(wr_clk), .rst_n(rst_n), .rst(wr_rst));
    xf13_rstsync #(.STAGES(SYNC)) u_rrst (.clk(rd_clk), .rst_n(rst_n), .rst(rd_rst));

    // write domain
    assign wr_full = (wr_code == ~rd_code_w);
    assign wr_fire = wr_en && !wr_full;

    xf13_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wptr (
        .clk(wr_clk), .rst(wr_rst), .step(wr_fire), .code(wr_code), .idx(wr_idx)
    );

    xf13_sync #(.W(JC_W), .STAGES(SYNC)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_code), .q(rd_code_w)
    );

    xf13_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_idx), .wdata(wr_data),
        .raddr(rd_idx), .rdata(mem_q)
    );

    // read domain
    assign rd_empty = (rd_code == wr_code_r);
    assign rd_fire  = rd_en && !rd_empty;

    xf13_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rptr (
        .clk(rd_clk), .rst(rd_rst), .step(rd_fire), .code(rd_code), .idx(rd_idx)
    );

    xf13_sync #(.W(JC_W), .STAGES(SYNC)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_code), .q(wr_code_r)
    );

    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= mem_q;
        end
    end
endmodule

// File: rtl/xf13_chk.sv
module xf13_chk #(
    parameter int unsigned DEPTH = 13,
    parameter int unsigned IDX_W = 4
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             wr_rst,
    input logic             rd_rst,
    input logic             wr_en,
    input logic             wr_full,
    input logic             rd_en,
    input logic             rd_empty,
    input logic             rd_valid,
    input logic [DEPTH-1:0] wcode,
    input logic [DEPTH-1:0] rcode,
    input logic [IDX_W-1:0] widx,
    input logic [IDX_W-1:0] ridx
);
    // R4
    full_freeze_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(wcode));

    // R2
    accept_moves_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_full) |=> (wcode != $past(wcode)));

    // R5
    empty_freeze_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> ($stable(rcode) && !rd_valid));

    // R6
    read_valid_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_empty) |=> rd_valid);

    // R8
    wcode_onebit_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wcode ^ $past(wcode)) <= 1);

    // R8
    rcode_onebit_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rcode ^ $past(rcode)) <= 1);

    // R7
    widx_range_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        32'(widx) < DEPTH);

    // R7
    ridx_range_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        32'(ridx) < DEPTH);
endmodule

bind xclk_fifo13 xf13_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
    .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en), .rd_empty(rd_empty),
    .rd_valid(rd_valid), .wcode(wr_code), .rcode(rd_code),
    .widx(wr_idx), .ridx(rd_idx)
);

// File: tb/tb_xclk_fifo13.sv
`timescale 1ns/1ps
module tb_xclk_fifo13;
    logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_full, rd_valid, rd_empty;
    logic [7:0] rd_data;

    xclk_fifo13 dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty)
    );

    always #4    wr_clk = ~wr_clk;   // 125 MHz
    always #5.65 rd_clk = ~rd_clk;

    int         n_chk = 0, n_bad = 0;
    logic [7:0] sb[$];
    int         rd_mode = 0;   // 0 idle, 1 always, 2 random
    bit         mon_on = 1'b0;
    bit         prev_fire = 1'b0;
    bit         finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // attempt one write this cycle; expected only if the queue had room
    task automatic wr_try(input logic [7:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        if (!wr_full) sb.push_back(d);
    endtask

    // write that waits for room
    task automatic wr_push(input logic [7:0] d);
        @(negedge wr_clk);
        while (wr_full) begin
            wr_en = 1'b0;
            @(negedge wr_clk);
        end
        wr_en = 1'b1;
        wr_data = d;
        sb.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        rd_mode = 1;
        while (sb.size() != 0 && guard < 20000) begin
            @(negedge rd_clk);
            guard++;
        end
        repeat (8) @(negedge rd_clk);
        check(sb.size() == 0, req, sb.size(), 0);
        check(rd_empty == 1'b1, req, rd_empty, 1);
    endtask

    // monitor: compares each valid byte against the scoreboard
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (rd_valid) begin
                if (sb.size() == 0) check(1'b0, "R6 valid byte with none expected", 1, 0);
                else begin
                    logic [7:0] e;
                    e = sb.pop_front();
                    check(rd_data == e, "R2 byte order", rd_data, e);
                end
            end
            if (prev_fire) check(rd_valid == 1'b1, "R6 valid after accepted read", rd_valid, 1);
            else           check(rd_valid == 1'b0, "R5/R6 no valid without accepted read", rd_valid, 0);
            case (rd_mode)
                1:       rd_en = 1'b1;
                2:       rd_en = ($urandom_range(0, 2) == 0);
                default: rd_en = 1'b0;
            endcase
            prev_fire = rd_en && !rd_empty;
        end else begin
            rd_en = 1'b0;
            prev_fire = 1'b0;
        end
    end

    initial begin
        #1200000;
        check(1'b0, "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (6) @(negedge wr_clk);
        check(rd_empty == 1'b1, "R1 empty after reset", rd_empty, 1);
        check(wr_full == 1'b0, "R1 not full after reset", wr_full, 0);
        check(rd_valid == 1'b0, "R1 no valid after reset", rd_valid, 0);
        @(negedge rd_clk);
        mon_on = 1'b1;

        // R5: reads while empty are refused
        rd_mode = 1;
        repeat (20) @(negedge rd_clk);
        rd_mode = 0;
        repeat (2) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R5 still empty after refused reads", rd_empty, 1);

        // R3: fill with no reads
        for (int i = 0; i < 12; i++) wr_try(8'(8'h10 + i));
        wr_idle();
        repeat (3) @(negedge wr_clk);
        check(wr_full == 1'b0, "R3 not full at 12", wr_full, 0);
        check(sb.size() == 12, "R3 twelve accepted", sb.size(), 12);
        wr_try(8'h1C);
        wr_idle();
        check(wr_full == 1'b1, "R3 full right after 13th", wr_full, 1);
        begin
            int k = 0;
            while (rd_empty && k < 10) begin
                @(negedge rd_clk);
                k++;
            end
            check(rd_empty == 1'b0, "R9 empty clears after write", rd_empty, 0);
        end

        // R4: writes while full are ignored
        for (int i = 0; i < 5; i++) wr_try(8'(8'hE0 + i));
        wr_idle();
        check(sb.size() == 13, "R4 no extra accepted while full", sb.size(), 13);
        check(wr_full == 1'b1, "R4 still full", wr_full, 1);

        // R9: full clears after reads start
        rd_mode = 1;
        begin
            int k = 0;
            while (wr_full && k < 40) begin
                @(negedge wr_clk);
                k++;
            end
            check(wr_full == 1'b0, "R9 full clears after read", wr_full, 0);
        end
        drain("R4 drained in order");

        // R7: long stream across many wraps, random reads
        rd_mode = 2;
        for (int i = 0; i < 200; i++) wr_push(8'(i * 7 + 3));
        wr_idle();
        drain("R7 wrap stream drained");

        // R2: back-to-back writes with continuous reads
        rd_mode = 1;
        for (int i = 0; i < 60; i++) wr_push(8'(8'hA5 ^ i));
        wr_idle();
        drain("R2 steady stream drained");

        // R10: reset in mid-operation discards held bytes
        rd_mode = 0;
        for (int i = 0; i < 6; i++) wr_push(8'(8'h40 + i));
        wr_idle();
        repeat (5) @(negedge wr_clk);
        #1.3;
        mon_on = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        #0.5;
        check(rd_empty == 1'b1, "R1 empty during reset", rd_empty, 1);
        repeat (4) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (6) @(negedge wr_clk);
        check(rd_empty == 1'b1, "R10 empty after mid reset", rd_empty, 1);
        check(wr_full == 1'b0, "R10 not full after mid reset", wr_full, 0);
        check(rd_valid == 1'b0, "R10 no valid after mid reset", rd_valid, 0);
        @(negedge rd_clk);
        mon_on = 1'b1;
        for (int i = 0; i < 3; i++) wr_push(8'(8'h77 + i));
        wr_idle();
        drain("R10 only new bytes after reset");

        summary();
    end
endmodule